// File: doc/BRIEF.md
# Banked Vector Load/Store Unit

This block carries out the memory side of vector load and store operations for a small SIMD core. Storage is split into several independent banks, replicated once for a global space and once for a core-local space, so that lanes whose addresses fall in different banks are served in the same cycle. For every accepted operation the unit works out one address per lane, steers each active lane to the bank chosen by its low address bits, and collects load results back into lane order.

The supported operations are strided load and store (contiguous being stride 1), gather and scatter with a scalar base added to each lane address, a lane-index fill with no memory traffic, a one-location broadcast read, and a store of one selected lane. A lane mask and a vector length predicate the vector forms, and a lane that is predicated off never reaches a bank. When two or more lanes target one bank they are served over successive cycles, lowest lane first. A one-cycle completion pulse ends each operation.

Top module: `vec_lsu`

## Requirements
- R1: Strided load (op code 1): lane i reads address base + stride*i, wrapping modulo 2^AW, and the value appears in lane i of `rdata`, bits [i*DW +: DW].
- R2: Strided store (op code 2): lane i writes its `wdata` lane to base + stride*i; a later load of that address returns it.
- R3: Gather (op code 3) reads and scatter (op code 4) writes address base + lane_addr lane i for each active lane i.
- R4: Index fill (op code 0) sets lane i of `rdata` to i for each active lane and 0 otherwise, touches no bank, and raises `done` on the edge that accepts it.
- R5: Broadcast (op code 5) reads the single address base in one bank cycle and places that value in every lane, regardless of mask and length.
- R6: Single-lane store (op code 6) writes only lane `sel` of `wdata` to address base, in one bank cycle, ignoring mask and length; no other address changes.
- R7: For op codes 1 to 4 a lane is active only when its mask bit is 1 and its index is below `vlen`; inactive lanes issue no access and read back as 0, and no bank is accessed while the unit is idle.
- R8: The bank of an address is its low log2(BANKS) bits; each bank serves one lane per cycle in ascending lane order, so an operation takes as many bank cycles as the largest number of active lanes on one bank, and a scatter with repeated addresses leaves the highest lane's value.
- R9: `busy` rises on the edge that accepts `start` and stays high for exactly the bank cycles of R8; `done` pulses for one cycle on the edge where `busy` falls; `start` while busy is ignored.
- R10: `space` = 0 selects the global banks and 1 the local banks; the two spaces hold independent contents.
- R11: Reset (synchronous, `rst_n` low) clears `busy`, `done` and `rdata`, also in the middle of an operation. Store operations leave `rdata` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| op | input | 3 | Operation code (0 index, 1 strided load, 2 strided store, 3 gather, 4 scatter, 5 broadcast, 6 single-lane store) |
| space | input | 1 | Address space: 0 global, 1 local |
| base | input | AW | Scalar base address |
| stride | input | AW | Scalar element stride |
| lane_addr | input | LANES*AW | Per-lane offsets for gather/scatter |
| mask | input | LANES | Per-lane condition bits |
| vlen | input | $clog2(LANES+1) | Active vector length |
| sel | input | $clog2(LANES) | Lane picked by single-lane store |
| wdata | input | LANES*DW | Store data, lane i at [i*DW +: DW] |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | LANES*DW | Load results in lane order, valid from `done` until the next accept |

## Verification
With `start` sampled at edge k, `busy` is due high just after edge k whenever the operation has active lanes, and `done` is due just after edge k+N, where N is the per-bank maximum of active lanes (0 for the index fill and fully masked operations, 1 for broadcast and single-lane store). The bench computes N from the lane addresses itself, counts edges from the accepting edge, samples one time unit after each edge, and compares that count and every `rdata` lane at the `done` cycle. Store effects and the no-access cases are observed by later loads through the same ports against a bench-side memory image.

// File: rtl/vlsu_pkg.sv
// Package: operation codes and helpers shared by the load/store unit.
package vlsu_pkg;

    typedef enum logic [2:0] {
        OP_IDX  = 3'd0,
        OP_LDS  = 3'd1,
        OP_STS  = 3'd2,
        OP_GATH = 3'd3,
        OP_SCAT = 3'd4,
        OP_BCST = 3'd5,
        OP_ST1  = 3'd6
    } vop_e;

    // True for operations that move data from a bank into the result.
    function automatic logic op_reads(vop_e o);
        return (o == OP_LDS) || (o == OP_GATH) || (o == OP_BCST);
    endfunction

    // True for operations that write a bank.
    function automatic logic op_writes(vop_e o);
        return (o == OP_STS) || (o == OP_SCAT) || (o == OP_ST1);
    endfunction

endpackage

// File: rtl/vlsu_agen.sv
// Lane address generator. Purely combinational: from the request fields it
// forms one address per lane and the set of lanes that must reach a bank.
// Assumes power-of-two address space; sums wrap modulo 2^AW.
module vlsu_agen
    import vlsu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int AW    = 6,
    localparam int LW   = $clog2(LANES + 1),
    localparam int SW   = $clog2(LANES)
) (
    input  vop_e                       op,
    input  logic [AW-1:0]              base,
    input  logic [AW-1:0]              stride,
    input  logic [LANES-1:0][AW-1:0]   lane_off,
    input  logic [LANES-1:0]           mask,
    input  logic [LW-1:0]              vlen,
    input  logic [SW-1:0]              sel,
    output logic [LANES-1:0][AW-1:0]   addr,
    output logic [LANES-1:0]           act,
    output logic [LANES-1:0]           lane_on
);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // Per-lane predicate and address for the selected operation.
        always_comb begin
            lane_on[i] = mask[i] && (i < int'(vlen));
            addr[i]    = base;
            act[i]     = 1'b0;
            case (op)
                OP_LDS, OP_STS: begin
                    addr[i] = base + AW'(stride * AW'(i));
                    act[i]  = lane_on[i];
                end
                OP_GATH, OP_SCAT: begin
                    addr[i] = base + lane_off[i];
                    act[i]  = lane_on[i];
                end
                OP_BCST: act[i] = (i == 0);
                OP_ST1:  act[i] = (int'(sel) == i);
                default: act[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/vlsu_arb.sv
// Bank arbiter and crossbar select. Combinational: for each bank it picks the
// lowest-numbered pending lane whose address maps to that bank, and reports
// which lanes were granted this cycle. Assumes BANKS >= 2.
module vlsu_arb #(
    parameter int LANES = 4,
    parameter int BANKS = 4,
    localparam int BB   = $clog2(BANKS),
    localparam int LIW  = $clog2(LANES)
) (
    input  logic [LANES-1:0]           pending,
    input  logic [LANES-1:0][BB-1:0]   bank_idx,
    output logic [BANKS-1:0]           hit,
    output logic [BANKS-1:0][LIW-1:0]  lane_of,
    output logic [LANES-1:0]           grant
);

    // Lowest pending lane per bank (descending scan, last match wins).
    always_comb begin
        hit     = '0;
        lane_of = '0;
        for (int b = 0; b < BANKS; b++) begin
            for (int i = LANES - 1; i >= 0; i--) begin
                if (pending[i] && (bank_idx[i] == BB'(b))) begin
                    hit[b]     = 1'b1;
                    lane_of[b] = LIW'(i);
                end
            end
        end
    end

    // A lane is granted when it is the winner of its own bank.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            grant[i] = pending[i] && hit[bank_idx[i]] &&
                       (lane_of[bank_idx[i]] == LIW'(i));
        end
    end

endmodule

// File: rtl/vlsu_bank.sv
// One storage bank: combinational read, write on the clock edge.
// Contents are not reset; the caller must write before reading.
module vlsu_bank #(
    parameter int DW    = 16,
    parameter int DEPTH = 16,
    localparam int RW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [RW-1:0] row,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) mem[row] <= wdata;
    end

    // Read port.
    assign rdata = mem[row];

endmodule

// File: rtl/vec_lsu.sv
// Banked vector load/store unit. Accepts one operation when idle, latches the
// lane addresses, then serves pending lanes one per bank per cycle until none
// remain, pulsing done on the final edge. Banks are replicated per address
// space (0 global, 1 local). Assumes LANES and BANKS are powers of two >= 2.
module vec_lsu
    import vlsu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int BANKS = 4,
    parameter int AW    = 6,
    parameter int DW    = 16,
    localparam int LW    = $clog2(LANES + 1),
    localparam int SW    = $clog2(LANES),
    localparam int BB    = $clog2(BANKS),
    localparam int DEPTH = (1 << AW) / BANKS,
    localparam int NSP   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [2:0]           op,
    input  logic                 space,
    input  logic [AW-1:0]        base,
    input  logic [AW-1:0]        stride,
    input  logic [LANES*AW-1:0]  lane_addr,
    input  logic [LANES-1:0]     mask,
    input  logic [LW-1:0]        vlen,
    input  logic [SW-1:0]        sel,
    input  logic [LANES*DW-1:0]  wdata,
    output logic                 busy,
    output logic                 done,
    output logic [LANES*DW-1:0]  rdata
);

    // Latched operation state.
    logic                        busy_q, done_q, space_q;
    vop_e                        op_q;
    logic [LANES-1:0][AW-1:0]    addr_q;
    logic [LANES-1:0]            pend_q;
    logic [LANES-1:0][DW-1:0]    wd_q, res_q;

    // Generator outputs for the request on the ports.
    logic [LANES-1:0][AW-1:0]    g_addr;
    logic [LANES-1:0]            g_act, g_on;

    // Arbiter signals and bank traffic.
    logic [LANES-1:0][BB-1:0]    bank_idx;
    logic [BANKS-1:0]            hit;
    logic [BANKS-1:0][SW-1:0]    lane_of;
    logic [LANES-1:0]            grant;
    logic [NSP-1:0][BANKS-1:0]   bank_we;
    logic [NSP-1:0][BANKS-1:0][DW-1:0] bank_rd;
    logic [LANES-1:0][DW-1:0]    lane_rd;
    logic                        accept;
    logic [LANES-1:0]            pend_nx;

    assign accept  = start && !busy_q;
    assign pend_nx = pend_q & ~grant;

    vlsu_agen #(.LANES(LANES), .AW(AW)) u_agen (
        .op      (vop_e'(op)),
        .base    (base),
        .stride  (stride),
        .lane_off(lane_addr),
        .mask    (mask),
        .vlen    (vlen),
        .sel     (sel),
        .addr    (g_addr),
        .act     (g_act),
        .lane_on (g_on)
    );

    // Bank index of each latched lane address (low address bits).
    always_comb begin
        for (int i = 0; i < LANES; i++) bank_idx[i] = addr_q[i][BB-1:0];
    end

    vlsu_arb #(.LANES(LANES), .BANKS(BANKS)) u_arb (
        .pending (pend_q),
        .bank_idx(bank_idx),
        .hit     (hit),
        .lane_of (lane_of),
        .grant   (grant)
    );

    for (genvar s = 0; s < NSP; s++) begin : g_space
        for (genvar b = 0; b < BANKS; b++) begin : g_bank
            assign bank_we[s][b] = op_writes(op_q) && hit[b] && (space_q == s);
            vlsu_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
                .clk  (clk),
                .we   (bank_we[s][b]),
                .row  (addr_q[lane_of[b]][AW-1:BB]),
                .wdata(wd_q[lane_of[b]]),
                .rdata(bank_rd[s][b])
            );
        end
    end

    // Crossbar return path: each lane picks its bank's read data.
    always_comb begin
        for (int i = 0; i < LANES; i++) lane_rd[i] = bank_rd[space_q][bank_idx[i]];
    end

    // Operation sequencing, lane retirement and result capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
            space_q <= 1'b0;
            op_q    <= OP_IDX;
            addr_q  <= '0;
            pend_q  <= '0;
            wd_q    <= '0;
            res_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                op_q    <= vop_e'(op);
                space_q <= space;
                addr_q  <= g_addr;
                pend_q  <= g_act;
                wd_q    <= wdata;
                for (int i = 0; i < LANES; i++)
                    res_q[i] <= (vop_e'(op) == OP_IDX && g_on[i]) ? DW'(i) : '0;
                if (g_act == '0) done_q <= 1'b1;
                else             busy_q <= 1'b1;
            end else if (busy_q) begin
                for (int i = 0; i < LANES; i++) begin
                    if (op_reads(op_q) && grant[i]) res_q[i] <= lane_rd[i];
                    if (op_q == OP_BCST && grant[0]) res_q[i] <= lane_rd[0];
                end
                pend_q <= pend_nx;
                if (pend_nx == '0) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign busy  = busy_q;
    assign done  = done_q;
    assign rdata = res_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);                                               // R9
    AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_q && done_q));                                              // R9
    AST_BANK_PROGRESS: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> $countones(pend_q) < $countones($past(pend_q)));        // R8
    AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> (bank_we == '0));                                      // R7
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && start) |=> ($stable(op_q) && $stable(addr_q) && $stable(wd_q))); // R9

endmodule

// File: tb/tb_vec_lsu.sv
// Self-checking bench: table-driven operations against a memory image kept in
// the bench, then directed reset and busy-time tests.
module tb_vec_lsu;

    localparam int LANES = 4, BANKS = 4, AW = 6, DW = 16;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, space = 1'b0;
    logic [2:0]  op = '0;
    logic [5:0]  base = '0, stride = '0;
    logic [23:0] lane_addr = '0;
    logic [3:0]  mask = '0;
    logic [2:0]  vlen = '0;
    logic [1:0]  sel = '0;
    logic [63:0] wdata = '0;
    logic        busy, done;
    logic [63:0] rdata;

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [15:0] gm [64];
    logic [15:0] lm [64];

    always #4 clk = ~clk;

    vec_lsu #(.LANES(LANES), .BANKS(BANKS), .AW(AW), .DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .space(space),
        .base(base), .stride(stride), .lane_addr(lane_addr), .mask(mask),
        .vlen(vlen), .sel(sel), .wdata(wdata), .busy(busy), .done(done),
        .rdata(rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic [2:0]  op;
        logic        sp;
        logic [5:0]  base;
        logic [5:0]  stride;
        logic [23:0] la;
        logic [3:0]  mask;
        logic [2:0]  vlen;
        logic [1:0]  sel;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t TBL [NV] = '{
        '{3'd1, 1'b0, 6'd5,  6'd1, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd1, 1'b0, 6'd0,  6'd4, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd1, 1'b0, 6'd3,  6'd2, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd1, 1'b1, 6'd62, 6'd1, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd1, 1'b0, 6'd0,  6'd1, 24'd0, 4'hA, 3'd4, 2'd0},
        '{3'd1, 1'b0, 6'd8,  6'd1, 24'd0, 4'hF, 3'd2, 2'd0},
        '{3'd3, 1'b0, 6'd10, 6'd0, {6'd20, 6'd1, 6'd33, 6'd0}, 4'hF, 3'd4, 2'd0},
        '{3'd4, 1'b0, 6'd16, 6'd0, {6'd1, 6'd0, 6'd4, 6'd0},   4'hF, 3'd4, 2'd0},
        '{3'd3, 1'b0, 6'd16, 6'd0, {6'd0, 6'd4, 6'd1, 6'd0},   4'hF, 3'd4, 2'd0},
        '{3'd5, 1'b1, 6'd7,  6'd0, 24'd0, 4'h0, 3'd0, 2'd0},
        '{3'd0, 1'b0, 6'd0,  6'd0, 24'd0, 4'hB, 3'd3, 2'd0},
        '{3'd6, 1'b0, 6'd40, 6'd0, 24'd0, 4'h0, 3'd0, 2'd2},
        '{3'd1, 1'b0, 6'd38, 6'd1, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd2, 1'b1, 6'd2,  6'd3, 24'd0, 4'h6, 3'd4, 2'd0},
        '{3'd1, 1'b1, 6'd2,  6'd3, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd1, 1'b0, 6'd2,  6'd3, 24'd0, 4'hF, 3'd4, 2'd0},
        '{3'd2, 1'b0, 6'd0,  6'd1, 24'd0, 4'hF, 3'd0, 2'd0},
        '{3'd1, 1'b0, 6'd0,  6'd1, 24'd0, 4'hF, 3'd4, 2'd0}
    };

    function automatic string tag_of(input int k);
        case (k)
            0:  return "R1 contiguous load";
            1:  return "R8 all lanes on one bank";
            2:  return "R1 strided load two per bank";
            3:  return "R10 local load with wrap";
            4:  return "R7 masked load";
            5:  return "R7 short vector length";
            6:  return "R3 gather";
            7:  return "R8 scatter repeated address";
            8:  return "R3 gather after scatter";
            9:  return "R5 broadcast";
            10: return "R4 index fill";
            11: return "R6 single-lane store";
            12: return "R6 neighbours unchanged";
            13: return "R2 masked strided store";
            14: return "R2 strided readback";
            15: return "R10 other space untouched";
            16: return "R7 zero length store";
            default: return "R7 readback after empty store";
        endcase
    endfunction

    // Issue one operation, model it, and check cycle count and results.
    task automatic run(input logic [2:0] o, input logic sp, input logic [5:0] b,
                       input logic [5:0] st, input logic [23:0] la, input logic [3:0] m,
                       input logic [2:0] vl, input logic [1:0] sl, input logic [63:0] wd,
                       input bit poke, input string tag);
        logic [5:0]  a [4];
        bit          act [4];
        bit          on;
        logic [63:0] exp;
        int          cnt [4];
        int          rounds, n;
        exp = '0;
        rounds = 0;
        for (int i = 0; i < 4; i++) cnt[i] = 0;
        for (int i = 0; i < 4; i++) begin
            on = m[i] && (i < int'(vl));
            a[i] = b;
            act[i] = 0;
            case (o)
                3'd1, 3'd2: begin a[i] = b + 6'(st * i); act[i] = on; end
                3'd3, 3'd4: begin a[i] = b + la[i*6 +: 6]; act[i] = on; end
                3'd5: act[i] = (i == 0);
                3'd6: act[i] = (int'(sl) == i);
                default: act[i] = 0;
            endcase
            if (act[i]) cnt[a[i][1:0]]++;
            if (o == 3'd0 && on) exp[i*16 +: 16] = 16'(i);
            if ((o == 3'd1 || o == 3'd3) && act[i]) exp[i*16 +: 16] = sp ? lm[a[i]] : gm[a[i]];
        end
        for (int i = 0; i < 4; i++) if (cnt[i] > rounds) rounds = cnt[i];
        if (o == 3'd5)
            for (int i = 0; i < 4; i++) exp[i*16 +: 16] = sp ? lm[b] : gm[b];
        @(negedge clk);
        op = o; space = sp; base = b; stride = st; lane_addr = la;
        mask = m; vlen = vl; sel = sl; wdata = wd; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy == (rounds > 0), {tag, " / R9 busy after accept"}, 64'(busy), 64'(rounds > 0));
        n = 0;
        while (!done && n < 20) begin
            if (poke && n == 0) begin
                @(negedge clk);
                op = 3'd4; space = sp; base = 6'd0; lane_addr = '0;
                mask = 4'hF; vlen = 3'd4; wdata = 64'hDEAD_DEAD_DEAD_DEAD; start = 1'b1;
            end
            @(posedge clk); #1;
            start = 1'b0;
            n++;
        end
        chk(n == rounds, {tag, " / R8 R9 bank cycles"}, 64'(n), 64'(rounds));
        chk(done && !busy, {tag, " / R9 done with busy low"}, {done, busy}, 64'b10);
        chk(rdata == exp, {tag, " / R11 R1 result lanes"}, rdata, exp);
        @(posedge clk); #1;
        chk(!done, {tag, " / R9 done is one pulse"}, 64'(done), 64'd0);
        if (o == 3'd2 || o == 3'd4 || o == 3'd6)
            for (int i = 0; i < 4; i++)
                if (act[i]) begin
                    if (sp) lm[a[i]] = wd[i*16 +: 16];
                    else    gm[a[i]] = wd[i*16 +: 16];
                end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        logic [63:0] w;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && rdata == '0, "R11 reset state", {busy, done, rdata[61:0]}, 64'd0);
        rst_n = 1'b1;
        // Fill both spaces with contiguous stores.
        for (int s = 0; s < 2; s++)
            for (int k = 0; k < 16; k++) begin
                for (int i = 0; i < 4; i++)
                    w[i*16 +: 16] = s ? 16'h8000 + 16'(4*k + i) : 16'h1000 + 16'(3*(4*k + i));
                run(3'd2, s[0], 6'(4*k), 6'd1, '0, 4'hF, 3'd4, 2'd0, w, 0, "R2 fill store");
            end
        // Table walk; entry 1 also pulses start while busy.
        for (int k = 0; k < NV; k++) begin
            for (int i = 0; i < 4; i++) w[i*16 +: 16] = 16'hA000 + 16'(k*16 + i);
            run(TBL[k].op, TBL[k].sp, TBL[k].base, TBL[k].stride, TBL[k].la, TBL[k].mask,
                TBL[k].vlen, TBL[k].sel, w, k == 1, tag_of(k));
        end
        // R9: the ignored scatter must not have reached memory.
        run(3'd1, 1'b0, 6'd0, 6'd1, '0, 4'hF, 3'd4, 2'd0, '0, 0, "R9 ignored start wrote nothing");
        // R11: reset in the middle of a four-cycle load.
        @(negedge clk);
        op = 3'd1; space = 1'b0; base = 6'd0; stride = 6'd4; mask = 4'hF; vlen = 3'd4; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        chk(busy, "R11 busy before mid-run reset", 64'(busy), 64'd1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk(!busy && !done && rdata == '0, "R11 mid-run reset clears", {busy, done, rdata[61:0]}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        run(3'd3, 1'b1, 6'd0, 6'd0, {6'd9, 6'd8, 6'd5, 6'd2}, 4'hF, 3'd4, 2'd0, '0, 0, "R10 local gather after reset");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule